// File: doc/BRIEF.md
# Head Load and Engage Controller

This block owns the head-load line of a floppy disk controller. A command decoder reports each accepted command with a one-cycle start strobe, a kind code and its flags. From these the block decides when the read/write head is pressed against the media and when it is lifted. It also models the external timer that reports full engagement some time after the load line rises. The load line and that engagement signal are combined into one head-engaged status bit.

Commands that must touch the media first wait out a fixed settling delay when their flags ask for one. They then wait for the head to be engaged. A single `access_ok` pulse tells the command engine it may start reading. When the controller is not busy, the head is lifted on its own after a fixed number of index pulses.

Top module: `head_load_ctrl`

## Requirements
- R1: While reset is held, and right after it, `hld`, `hlt`, `head_engaged`, `settle_busy` and `access_ok` are all 0.
- R2: A start with kind 1 (positioning command) and `flag_h`=1 sets `hld` at the first clock edge that samples the start.
- R3: A kind-1 start with `flag_h`=0 and `flag_v`=1 leaves `hld` as it was. `hld` is then set at the edge that samples `step_done`, and at that same edge the settling delay begins.
- R4: A start with kind 2 (sector command) or kind 3 (track command) sets `hld` at the first edge, whatever its flags.
- R5: A kind-1 start with `flag_h`=0 and `flag_v`=0 clears `hld` at the first edge. No settling delay follows and no `access_ok` is given. A start with kind 0 changes nothing.
- R6: While `busy` is low, the edge that samples the IDLE_INDEX-th `index_pulse` (15 by default) clears `hld`. The pulse count restarts whenever `busy` is high or a command starts.
- R7: `hlt` rises exactly ENGAGE_CYC cycles after a rising edge of `hld`. It is not restarted while `hld` stays high, and it drops at the same edge as `hld`.
- R8: `head_engaged` is high only while both `hld` and `hlt` are high.
- R9: `settle_busy` stays high for exactly SETTLE_CYC cycles. It runs after `step_done` for a kind-1 command with `flag_v`=1, and at once for kind 2 or 3 with `flag_e`=1. Kind 2 or 3 with `flag_e`=0 gets no delay.
- R10: `access_ok` is a single-cycle pulse. It comes only once any settling delay has ended and only while `head_engaged` is high.
- R11: A new start abandons any pending step wait, settling delay or engagement wait. A `step_done` after a start that needs no verify has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_start | input | 1 | One-cycle strobe for an accepted command |
| cmd_type | input | 2 | Command kind: 0 none, 1 positioning, 2 sector, 3 track |
| flag_h | input | 1 | Load head at the start of a positioning command |
| flag_v | input | 1 | Verify after positioning |
| flag_e | input | 1 | Insert settling delay for sector or track commands |
| step_done | input | 1 | One-cycle strobe after the last step pulse |
| busy | input | 1 | Controller busy flag |
| index_pulse | input | 1 | One-cycle strobe per disk revolution |
| hld | output | 1 | Head-load drive |
| hlt | output | 1 | Modelled head-engaged timer output |
| head_engaged | output | 1 | Status bit: head loaded and engaged |
| settle_busy | output | 1 | Settling delay in progress |
| access_ok | output | 1 | One-cycle grant to begin media access |

## Verification
A corrupted sequencer state shows up in the same cycle as a wrong `settle_busy` or as an `access_ok` that comes too early or never comes. A wrong settling count moves the falling edge of `settle_busy` by exactly that error. A bad engage counter shifts the rise of `hlt` and `head_engaged` away from cycle ENGAGE_CYC. A miscounting index watcher lifts `hld` one or more pulses early or late, which is visible at the 14th and 15th pulse.

// File: rtl/hl_pkg.sv
package hl_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_POS  = 2'd1,
    CMD_SECT = 2'd2,
    CMD_TRK  = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_PEND_STEP,
    SQ_SETTLE,
    SQ_WAIT_ENG
  } seq_state_e;
endpackage

// File: rtl/hl_index_watch.sv
module hl_index_watch #(
  parameter int unsigned IDLE_INDEX = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic cmd_valid,
  input  logic index_pulse,
  output logic release_pulse
);
  localparam int unsigned CW = $clog2(IDLE_INDEX + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d         = cnt_q;
    cnt_en        = 1'b0;
    release_pulse = 1'b0;
    if (busy || cmd_valid) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (index_pulse) begin
      cnt_en = 1'b1;
      if (cnt_q == CW'(IDLE_INDEX - 1)) begin
        cnt_d         = '0;
        release_pulse = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hl_engage_timer.sv
module hl_engage_timer #(
  parameter int unsigned ENGAGE_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hld,
  output logic hlt
);
  localparam int unsigned CW = $clog2(ENGAGE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!hld) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != CW'(ENGAGE_CYC)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hlt = hld && (cnt_q == CW'(ENGAGE_CYC));
endmodule

// File: rtl/hl_seq.sv
module hl_seq
  import hl_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 30000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_type,
  input  logic       flag_h,
  input  logic       flag_v,
  input  logic       flag_e,
  input  logic       step_done,
  input  logic       release_pulse,
  input  logic       hlt,
  output logic       hld,
  output logic       settle_busy,
  output logic       access_ok
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

  cmd_kind_e     kind;
  seq_state_e    st_q, st_d;
  logic [CW-1:0] sc_q, sc_d;
  logic          hld_q, hld_d;

  assign kind = cmd_kind_e'(cmd_type);

  always_comb begin
    st_d  = st_q;
    sc_d  = sc_q;
    hld_d = hld_q;
    if (cmd_valid) begin
      if (kind == CMD_POS) begin
        if (flag_h) hld_d = 1'b1;
        else if (!flag_v) hld_d = 1'b0;
        st_d = flag_v ? SQ_PEND_STEP : SQ_IDLE;
      end else begin
        hld_d = 1'b1;
        if (flag_e) begin
          st_d = SQ_SETTLE;
          sc_d = CW'(SETTLE_CYC - 1);
        end else begin
          st_d = SQ_WAIT_ENG;
        end
      end
    end else begin
      if (release_pulse) hld_d = 1'b0;
      unique case (st_q)
        SQ_PEND_STEP: if (step_done) begin
          hld_d = 1'b1;
          st_d  = SQ_SETTLE;
          sc_d  = CW'(SETTLE_CYC - 1);
        end
        SQ_SETTLE: begin
          if (sc_q == '0) st_d = SQ_WAIT_ENG;
          else sc_d = sc_q - 1'b1;
        end
        SQ_WAIT_ENG: if (hld_q && hlt) st_d = SQ_IDLE;
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      sc_q  <= '0;
      hld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      hld_q <= hld_d;
      if (sc_d != sc_q) sc_q <= sc_d;
    end
  end

  assign hld         = hld_q;
  assign settle_busy = (st_q == SQ_SETTLE);
  assign access_ok   = (st_q == SQ_WAIT_ENG) && hld_q && hlt;
endmodule

// File: rtl/head_load_ctrl.sv
module head_load_ctrl
  import hl_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 30000,
  parameter int unsigned ENGAGE_CYC = 100000,
  parameter int unsigned IDLE_INDEX = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic [1:0] cmd_type,
  input  logic       flag_h,
  input  logic       flag_v,
  input  logic       flag_e,
  input  logic       step_done,
  input  logic       busy,
  input  logic       index_pulse,
  output logic       hld,
  output logic       hlt,
  output logic       head_engaged,
  output logic       settle_busy,
  output logic       access_ok
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       cmd_valid;
  logic       release_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign cmd_valid = cmd_start && (cmd_kind_e'(cmd_type) != CMD_NONE);

  hl_index_watch #(.IDLE_INDEX(IDLE_INDEX)) u_idx (
    .clk(clk), .rst_n(rst_sync_n), .busy(busy), .cmd_valid(cmd_valid),
    .index_pulse(index_pulse), .release_pulse(release_pulse)
  );

  hl_engage_timer #(.ENGAGE_CYC(ENGAGE_CYC)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .hld(hld), .hlt(hlt)
  );

  hl_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .flag_h(flag_h), .flag_v(flag_v), .flag_e(flag_e), .step_done(step_done),
    .release_pulse(release_pulse), .hlt(hlt), .hld(hld),
    .settle_busy(settle_busy), .access_ok(access_ok)
  );

  assign head_engaged = hld && hlt;
endmodule

// File: rtl/hl_checker.sv
module hl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic [1:0] cmd_type,
  input logic       flag_h,
  input logic       flag_v,
  input logic       hld,
  input logic       hlt,
  input logic       head_engaged,
  input logic       settle_busy,
  input logic       access_ok
);
  AST_HLD_ON_LOADFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && cmd_type == 2'd1 && flag_h |=> hld); // R2
  AST_HLD_ON_DATACMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && cmd_type[1] |=> hld); // R4
  AST_HLD_OFF_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start && cmd_type == 2'd1 && !flag_h && !flag_v |=> !hld && !settle_busy); // R5
  AST_HLT_NEEDS_HLD: assert property (@(posedge clk) disable iff (!rst_n)
    hlt |-> hld); // R7
  AST_HLT_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlt) |-> $past(hld)); // R7
  AST_ENGAGED_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    head_engaged |-> hld && hlt); // R8
  AST_NO_ACCESS_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
    settle_busy |-> !access_ok); // R9
  AST_ACCESS_ENGAGED: assert property (@(posedge clk) disable iff (!rst_n)
    access_ok |-> head_engaged); // R10
  AST_ACCESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    access_ok && !cmd_start |=> !access_ok); // R10
endmodule

bind head_load_ctrl hl_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cmd_start(cmd_start), .cmd_type(cmd_type),
  .flag_h(flag_h), .flag_v(flag_v), .hld(hld), .hlt(hlt),
  .head_engaged(head_engaged), .settle_busy(settle_busy), .access_ok(access_ok)
);

// File: tb/head_load_ctrl_bench.sv
`timescale 1ns/1ps
module head_load_ctrl_bench;
  localparam int unsigned SETTLE = 8;
  localparam int unsigned ENGAGE = 20;
  localparam int unsigned IDLEX  = 15;
  localparam int NVEC = 10;
  // {kind[1:0], h, v, e, expected hld, expected settle_busy}
  localparam logic [6:0] VEC [NVEC] = '{
    7'b01_000_0_0, 7'b01_100_1_0, 7'b01_010_1_0, 7'b01_000_0_0, 7'b01_010_0_0,
    7'b10_000_1_0, 7'b01_000_0_0, 7'b11_001_1_1, 7'b10_001_1_1, 7'b01_110_1_0
  };

  logic clk, rst_n, cmd_start, flag_h, flag_v, flag_e, step_done, busy, index_pulse;
  logic [1:0] cmd_type;
  logic hld, hlt, head_engaged, settle_busy, access_ok;
  int checks, errors, cyc;

  head_load_ctrl #(.SETTLE_CYC(SETTLE), .ENGAGE_CYC(ENGAGE), .IDLE_INDEX(IDLEX)) u_head_load_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_type(cmd_type),
    .flag_h(flag_h), .flag_v(flag_v), .flag_e(flag_e), .step_done(step_done),
    .busy(busy), .index_pulse(index_pulse), .hld(hld), .hlt(hlt),
    .head_engaged(head_engaged), .settle_busy(settle_busy), .access_ok(access_ok)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic h, input logic v, input logic e);
    cmd_type = k; flag_h = h; flag_v = v; flag_e = e; cmd_start = 1'b1;
    tick();
    cmd_start = 1'b0;
  endtask

  task automatic idx_pulse();
    index_pulse = 1'b1; tick(); index_pulse = 1'b0; tick();
  endtask

  task automatic step_pulse();
    step_done = 1'b1; tick(); step_done = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    chk("R1 hld", hld, 1'b0); chk("R1 hlt", hlt, 1'b0);
    chk("R1 engaged", head_engaged, 1'b0); chk("R1 settle", settle_busy, 1'b0);
    chk("R1 access", access_ok, 1'b0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk("R1 hld after release", hld, 1'b0);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0;
    cmd_start = 0; cmd_type = 0; flag_h = 0; flag_v = 0; flag_e = 0;
    step_done = 0; busy = 0; index_pulse = 0; rst_n = 0;
    do_reset();

    // Vector table: R2 R3 R4 R5 R9 on command starts
    for (int i = 0; i < NVEC; i++) begin
      issue(VEC[i][6:5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R2/R3/R4/R5 vec%0d hld", i), hld, VEC[i][1]);
      chk($sformatf("R9 vec%0d settle", i), settle_busy, VEC[i][0]);
    end

    // R7 R8: engage timing
    do_reset();
    issue(2'd1, 1, 0, 0);
    chk("R2 hld set", hld, 1'b1);
    chk("R7 hlt low at rise", hlt, 1'b0);
    for (int i = 1; i < int'(ENGAGE); i++) tick();
    chk("R7 hlt before limit", hlt, 1'b0);
    chk("R8 engaged before limit", head_engaged, 1'b0);
    tick();
    chk("R7 hlt at limit", hlt, 1'b1);
    chk("R8 engaged at limit", head_engaged, 1'b1);

    // R10: data command with head already engaged
    issue(2'd2, 0, 0, 0);
    chk("R10 immediate access", access_ok, 1'b1);
    tick();
    chk("R10 single pulse", access_ok, 1'b0);

    // R6: idle release after index count
    for (int i = 0; i < int'(IDLEX) - 1; i++) idx_pulse();
    chk("R6 hld before last index", hld, 1'b1);
    index_pulse = 1'b1; tick(); index_pulse = 1'b0;
    chk("R6 hld released", hld, 1'b0);
    chk("R7 hlt drops with hld", hlt, 1'b0);
    tick();

    // R6: busy clears the count
    issue(2'd1, 1, 0, 0);
    for (int i = 0; i < 10; i++) idx_pulse();
    busy = 1'b1; tick(); busy = 1'b0; tick();
    for (int i = 0; i < int'(IDLEX) - 1; i++) idx_pulse();
    chk("R6 busy restart count", hld, 1'b1);
    index_pulse = 1'b1; tick(); index_pulse = 1'b0;
    chk("R6 released after restart", hld, 1'b0);
    tick();

    // R3 R9 R10: verify flow from unloaded head
    issue(2'd1, 0, 1, 0);
    chk("R3 hld unchanged", hld, 1'b0);
    tick(); tick(); tick();
    chk("R3 wait for step", settle_busy, 1'b0);
    step_pulse();
    chk("R3 hld at step end", hld, 1'b1);
    chk("R3 settle starts", settle_busy, 1'b1);
    for (int i = 1; i < int'(SETTLE); i++) begin
      tick();
      chk("R9 settle running", settle_busy, 1'b1);
    end
    tick();
    chk("R9 settle ended", settle_busy, 1'b0);
    for (int i = int'(SETTLE) + 1; i < int'(ENGAGE); i++) tick();
    chk("R10 no access before engage", access_ok, 1'b0);
    tick();
    chk("R10 access at engage", access_ok, 1'b1);
    tick();
    chk("R10 access one cycle", access_ok, 1'b0);

    // R11: abort pending verify; step_done then ignored
    issue(2'd1, 0, 1, 0);
    issue(2'd1, 1, 0, 0);
    step_pulse();
    chk("R11 no settle after abort", settle_busy, 1'b0);
    chk("R11 hld kept", hld, 1'b1);
    // R5: kind 0 ignored
    issue(2'd0, 0, 0, 0);
    chk("R5 kind0 no effect", hld, 1'b1);
    // R9 R10: track command with delay blocks access while settling
    issue(2'd3, 0, 0, 1);
    chk("R9 track delay", settle_busy, 1'b1);
    chk("R10 blocked while settling", access_ok, 1'b0);
    for (int i = 1; i < int'(SETTLE); i++) tick();
    tick();
    chk("R10 access after delay", access_ok, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule